// File: doc/BRIEF.md
# Loadable serial-out shift register

This block is a register of `WIDTH` bits (eight by default), clocked on the rising edge of a free-running clock. On each enabled edge it does one of two things. It either captures a whole parallel word, or it moves its contents one place toward the top bit and takes a new bit from the serial input into bit 0. Only the top bit is visible outside, so the block works as a parallel-to-serial converter that sends the most significant bit first.

Three active-low controls set the behaviour. `clr_n` clears every bit at once, with no clock. `hold_n` is a synchronous clock enable: when it is high, an edge changes nothing. `load_n` chooses between parallel capture (low) and shifting (high). Clear takes priority over hold, hold over load, and load over shift. Two instances form a 16-bit converter when the serial output of one drives the serial input of the other. The stage that drives the final output holds the upper byte.

Top module: `piso_shift_reg`

## Requirements
- R1: While `clr_n` is low, `ser_out` is 0 and every stored bit is 0. This takes effect at once without a clock edge, and enabled load or shift edges that arrive during the clear do not change it.
- R2: At a rising edge with `hold_n` high, the stored word keeps its value whatever `load_n`, `par_in` and `ser_in` are.
- R3: At a rising edge with `hold_n` low and `load_n` low, bit i takes `par_in[i]` for every i, so `ser_out` shows `par_in[WIDTH-1]` after that edge.
- R4: At a rising edge with `hold_n` low and `load_n` high, bit 0 takes `ser_in` and bit i takes the old bit i-1 for i from 1 to WIDTH-1.
- R5: `ser_out` is always the stored bit WIDTH-1. After a load of value V, the next WIDTH-1 shifts present V bit WIDTH-2 down to bit 0, in that order.
- R6: `par_in` has no effect during a shift, and `ser_in` has no effect during a parallel load.
- R7: The first enabled edge after `clr_n` rises carries out the selected load or shift with no extra cycle of latency.
- R8: When two instances are chained, with the first stage's `ser_out` driving the `ser_in` of the output stage, a 16-bit word appears at the output stage bit 15 first. The output stage holds word bits 15..8 and the first stage holds bits 7..0.
- R9: A single hold cycle inside a shift stream repeats the current output bit once and delays the rest of the sequence by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock, free running |
| clr_n | input | 1 | Asynchronous clear, active low |
| hold_n | input | 1 | Synchronous enable, active low; high means hold |
| load_n | input | 1 | Low selects parallel load, high selects shift |
| par_in | input | WIDTH | Parallel data word |
| ser_in | input | 1 | Serial data entering bit 0 |
| ser_out | output | 1 | Stored bit WIDTH-1 |

## Verification
The directed part tests the following cases:
- A load of 0xA5 followed by shifts, compared against the word's own bits. This separates correct most-significant-bit-first ordering from a reversed or shifted order.
- A load of zero with `ser_in` held high, and shifts with random `par_in`. These show whether either unused input leaks into the register.
- Holds with noisy `load_n`, `par_in` and `ser_in`, including one hold inside a stream. These distinguish a true hold from a shift or reload, and show that the delay is exactly one cycle.
- A 16-bit chain with the words 0xBEEF and 0x1234, which checks the byte split and the link between the stages.
- Random control and data mixed with clears held across an edge, which tests the priority order against a bench model.

// File: rtl/psr_pkg.sv
package psr_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } op_e;
endpackage

// File: rtl/psr_mode_decode.sv
module psr_mode_decode
    import psr_pkg::*;
(
    input  logic hold_n,
    input  logic load_n,
    output op_e  op
);
    // Priority below the asynchronous clear: hold, then load, then shift.
    always_comb begin
        if (hold_n) begin
            op = OP_HOLD;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else begin
            op = OP_SHIFT;
        end
    end
endmodule

// File: rtl/psr_core.sv
module psr_core
    import psr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  op_e              op,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic             tail
);
    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        case (op)
            OP_LOAD:  state_d.bits = par_in;
            OP_SHIFT: state_d.bits = {state_q.bits[TOP-1:0], ser_in};
            default:  state_d.bits = state_q.bits;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tail = state_q.bits[TOP];

    // R1: the clear dominates at every edge it covers
    assert_clear_zero_R1: assert property (@(posedge clk)
        !clr_n |-> (state_q.bits == '0 && tail == 1'b0));

    // R2: hold keeps the word
    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_HOLD) |=> (state_q.bits == $past(state_q.bits)));

    // R3: parallel capture
    assert_load_capture_R3: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_LOAD) |=> (state_q.bits == $past(par_in)));

    // R4: one-place move with serial entry at bit 0
    assert_shift_move_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_SHIFT) |=> (state_q.bits == {$past(state_q.bits[TOP-1:0]), $past(ser_in)}));
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
    import psr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             hold_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic             ser_out
);
    op_e op;

    psr_mode_decode u_decode (
        .hold_n (hold_n),
        .load_n (load_n),
        .op     (op)
    );

    psr_core #(.WIDTH(WIDTH)) u_core (
        .clk    (clk),
        .clr_n  (clr_n),
        .op     (op),
        .par_in (par_in),
        .ser_in (ser_in),
        .tail   (ser_out)
    );

    // R5: after a load the output shows the captured top bit
    assert_load_top_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (!hold_n && !load_n) |=> (ser_out == $past(par_in[WIDTH-1])));
endmodule

// File: tb/piso_shift_reg_test.sv
module piso_shift_reg_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       clr_n, hold_n, load_n, ser_in, ser_out;
    logic [7:0] par_in;
    logic       c_hold_n, c_load_n, c_ser, c_mid, c_out;
    logic [15:0] c_word;

    logic [7:0]  exp_q;
    logic [15:0] cexp_q;
    int nchk = 0;
    int nfail = 0;

    piso_shift_reg #(.WIDTH(8)) uut (
        .clk(clk), .clr_n(clr_n), .hold_n(hold_n), .load_n(load_n),
        .par_in(par_in), .ser_in(ser_in), .ser_out(ser_out)
    );

    piso_shift_reg #(.WIDTH(8)) u_feed (
        .clk(clk), .clr_n(clr_n), .hold_n(c_hold_n), .load_n(c_load_n),
        .par_in(c_word[7:0]), .ser_in(c_ser), .ser_out(c_mid)
    );

    piso_shift_reg #(.WIDTH(8)) u_last (
        .clk(clk), .clr_n(clr_n), .hold_n(c_hold_n), .load_n(c_load_n),
        .par_in(c_word[15:8]), .ser_in(c_mid), .ser_out(c_out)
    );

    function automatic logic [7:0] model8(logic [7:0] cur, logic h_n, logic l_n,
                                          logic [7:0] p, logic s);
        if (h_n) return cur;
        if (!l_n) return p;
        return {cur[6:0], s};
    endfunction

    function automatic logic [15:0] model16(logic [15:0] cur, logic h_n, logic l_n,
                                            logic [15:0] p, logic s);
        if (h_n) return cur;
        if (!l_n) return p;
        return {cur[14:0], s};
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    task automatic chk(logic got, logic want, string tag);
        nchk++;
        if (got !== want) begin
            nfail++;
            $display("FAIL %s: got %b expected %b", tag, got, want);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (clr_n) begin
            exp_q  = model8(exp_q, hold_n, load_n, par_in, ser_in);
            cexp_q = model16(cexp_q, c_hold_n, c_load_n, c_word, c_ser);
        end else begin
            exp_q  = '0;
            cexp_q = '0;
        end
        #1;
    endtask

    task automatic op8(logic h_n, logic l_n, logic [7:0] p, logic s);
        hold_n = h_n; load_n = l_n; par_in = p; ser_in = s;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        nchk++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [15:0] w;
        logic [31:0] seed;
        seed = $urandom(32'd7331);
        clr_n = 1'b0; hold_n = 1'b0; load_n = 1'b0; par_in = 8'hFF; ser_in = 1'b1;
        c_hold_n = 1'b1; c_load_n = 1'b1; c_word = 16'h0; c_ser = 1'b0;
        exp_q = '0; cexp_q = '0;
        #3;
        chk(ser_out, 1'b0, "R1 reset state");
        chk(c_out, 1'b0, "R1 reset state chain");
        tick(); tick();
        chk(ser_out, 1'b0, "R1 clear overrides enabled load");

        // R7: first edge after release performs the load
        clr_n = 1'b1;
        op8(1'b0, 1'b0, 8'hA5, 1'b0);
        chk(ser_out, 1'b1, "R7 R3 load right after clear");

        // R5 / R6: ordered bits, par_in noise ignored during shifts
        v = 8'hA5;
        for (int k = 1; k < 8; k++) begin
            op8(1'b0, 1'b1, 8'($urandom), 1'b0);
            chk(ser_out, v[7-k], "R5 R6 A5 shift order");
        end
        op8(1'b0, 1'b1, 8'hFF, 1'b0);
        chk(ser_out, 1'b0, "R4 serial bit reaches top");

        // R6: ser_in ignored during load
        op8(1'b0, 1'b0, 8'h00, 1'b1);
        for (int k = 1; k < 8; k++) begin
            op8(1'b0, 1'b1, 8'hFF, 1'b0);
            chk(ser_out, 1'b0, "R6 ser_in ignored in load");
        end

        // R4: shift in a pattern then read it out
        v = 8'h3C;
        for (int k = 7; k >= 0; k--) op8(1'b0, 1'b1, 8'h00, v[k]);
        chk(ser_out, v[7], "R4 shifted-in word top");
        for (int k = 6; k >= 0; k--) begin
            op8(1'b0, 1'b1, 8'h00, 1'b0);
            chk(ser_out, v[k], "R4 shifted-in word order");
        end

        // R2: hold with noisy inputs
        op8(1'b0, 1'b0, 8'hC3, 1'b0);
        op8(1'b0, 1'b1, 8'h00, 1'b0);
        for (int k = 0; k < 3; k++) begin
            op8(1'b1, 1'(k[0]), 8'($urandom), 1'($urandom));
            chk(ser_out, 1'b1, "R2 hold keeps output");
        end
        op8(1'b0, 1'b1, 8'h00, 1'b0);
        chk(ser_out, 1'b0, "R2 hold kept whole word");

        // R9: one hold inside a stream
        v = 8'h96;
        op8(1'b0, 1'b0, v, 1'b0);
        chk(ser_out, v[7], "R9 stream start");
        op8(1'b0, 1'b1, 8'h00, 1'b0);
        chk(ser_out, v[6], "R9 stream bit6");
        op8(1'b0, 1'b1, 8'h00, 1'b0);
        chk(ser_out, v[5], "R9 stream bit5");
        op8(1'b1, 1'b1, 8'h00, 1'b1);
        chk(ser_out, v[5], "R9 hold repeats bit5");
        for (int k = 4; k >= 0; k--) begin
            op8(1'b0, 1'b1, 8'h00, 1'b0);
            chk(ser_out, v[k], "R9 delayed by one cycle");
        end

        // R8: 16-bit chain
        hold_n = 1'b1;
        foreach (w[i]) w[i] = 1'b0;
        for (int t = 0; t < 2; t++) begin
            w = (t == 0) ? 16'hBEEF : 16'h1234;
            c_hold_n = 1'b0; c_load_n = 1'b0; c_word = w; c_ser = 1'b1;
            tick();
            chk(c_out, w[15], "R8 chain first bit");
            c_load_n = 1'b1; c_ser = 1'b0; c_word = ~w;
            for (int k = 14; k >= 0; k--) begin
                tick();
                chk(c_out, w[k], "R8 chain order");
            end
        end

        // Random mix with clears held across an edge
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 40) == 0) begin
                clr_n = 1'b0;
                #2;
                chk(ser_out, 1'b0, "R1 async clear");
                chk(c_out, 1'b0, "R1 async clear chain");
                exp_q = '0; cexp_q = '0;
                tick();
                clr_n = 1'b1;
            end
            hold_n = 1'(($urandom % 4) == 0);
            load_n = 1'(($urandom % 5) != 0);
            par_in = 8'($urandom);
            ser_in = 1'($urandom);
            c_hold_n = 1'(($urandom % 4) == 0);
            c_load_n = 1'(($urandom % 6) != 0);
            c_word = 16'($urandom);
            c_ser = 1'($urandom);
            tick();
            chk(ser_out, exp_q[7], "R2 R3 R4 random");
            chk(c_out, cexp_q[15], "R8 random chain");
        end

        summary();
        $finish;
    end
endmodule